// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for the two-wire MDIO/MDC interface to an external Ethernet PHY. Software programs a 16-bit data register and an address-and-control register. The control register carries a busy flag, a direction flag, a clock-divider select, a 5-bit register number and a 5-bit PHY address. When software writes that register with the busy flag set, the block latches the fields. It then divides the system clock to produce MDC and shifts out one complete Clause 22 frame. For a write frame the data register supplies the payload. For a read frame the block releases MDIO and samples the PHY's reply into the data register. When the frame ends, the block clears busy.

Every frame lasts exactly 64 MDC periods. An MDC period is a whole number of system clocks picked from a fixed table. MDC is low for the first half of each bit and high for the second half. MDIO changes only as MDC falls, and input is sampled as MDC rises.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `addr_rd` and `data_rd` read 0, `mdc` is low and `mdio_oe` is low.
- R2: A control write accepted while idle stores the fields, which read back as {16'h0000, phy[15:11], reg[10:6], div[5:2], dir[1], busy[0]}. Bits 31:16 always read 0. Writing bit 0 as 1 starts a frame, and bit 0 reads 1 until the frame completes.
- R3: A control write made while busy reads 1 changes no field and does not disturb the frame in progress.
- R4: With bit 5 of the divider select clear, the MDC period in system clocks is: code 0→42, 1→62, 2→16, 3→26, 4→102, 5→124. The reserved codes 6 and 7 use 124.
- R5: With bit 5 set, the MDC period is: code 8→4, 9→6, 10→8, 11→10, 12→12, 13→14. Codes 14 and 15 use 4.
- R6: MDC idles low. During a frame, each of the 64 bit periods is low for half the divisor and then high for half. Busy clears on the same clock edge that ends the 64th period.
- R7: The frame bits, first to last, are: 32 ones, start 01, opcode (01 for a write, 10 for a read), PHY address MSB first, register number MSB first, turnaround, then 16 data bits MSB first. For a write, the turnaround is 10 and the data is the data register value taken when the frame starts.
- R8: For a read, `mdio_oe` is low from bit 46 through bit 63. `mdio_i` is sampled at the MDC rise of bits 48 to 63, MSB first. The result appears in `data_rd` when busy clears.
- R9: `mdio_o` changes only on the clock edge where MDC falls, or on the edge where a frame starts.
- R10: A control write with bit 0 clear, made while idle, updates the fields without starting a frame. MDC stays low and `mdio_oe` stays low.
- R11: A data write (`reg_sel` = 1) while idle loads `data_rd` with `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wdata | input | 16 | Write data |
| addr_rd | output | 32 | Control register readback |
| data_rd | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven toward the PHY |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen from the pad |

## Verification
The assertions assume that software respects the handshake. It does not write the data register while a frame is running, and it issues at most one write strobe per cycle. They also assume that `mdio_i` is stable around each MDC rise. The stimulus writes the data register only while busy reads 0. Its PHY model changes `mdio_i` only at falling system-clock edges, derived from the bench's own frame position. The single deliberate violation is a control write during busy, which exercises the ignore rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int DIV_W     = 8;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  // MDC period in system clocks for a 4-bit range select
  function automatic logic [DIV_W-1:0] mdc_divisor(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:  d = 8'd42;
      4'd1:  d = 8'd62;
      4'd2:  d = 8'd16;
      4'd3:  d = 8'd26;
      4'd4:  d = 8'd102;
      4'd5,
      4'd6,
      4'd7:  d = 8'd124;
      4'd9:  d = 8'd6;
      4'd10: d = 8'd8;
      4'd11: d = 8'd10;
      4'd12: d = 8'd12;
      4'd13: d = 8'd14;
      default: d = 8'd4;
    endcase
    return d;
  endfunction

  // Whole frame, first transmitted bit in the MSB
  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic              wr,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regn,
      input logic [DATA_W-1:0] data);
    return {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regn,
            (wr ? 2'b10 : 2'b00), (wr ? data : {DATA_W{1'b0}})};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  localparam int HW = DIV_W - 1;

  logic [HW-1:0] half;
  logic [HW-1:0] hcnt;
  logic          last;

  assign half     = divisor[DIV_W-1:1];
  assign last     = (hcnt == half - 1'b1);
  assign rise_evt = run && last && !mdc;
  assign fall_evt = run && last && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      mdc  <= 1'b0;
    end else if (!run) begin
      hcnt <= '0;
      mdc  <= 1'b0;
    end else if (last) begin
      hcnt <= '0;
      mdc  <= ~mdc;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R4 / R5: the half-period counter never passes the selected half divisor
  a_r4_count_below_half: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt < half));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  logic                 active;
  logic                 is_wr;
  logic [IDX_W-1:0]     bitidx;
  logic [FRAME_LEN-1:0] sh;
  logic [DATA_W-1:0]    rsh;
  logic                 last_bit;
  logic                 capture;

  assign last_bit = (bitidx == IDX_W'(FRAME_LEN - 1));
  assign done     = active && fall_evt && last_bit;
  assign capture  = active && rise_evt && !is_wr && (bitidx >= IDX_W'(DATA_POS));
  assign mdio_o   = active && sh[FRAME_LEN-1];
  assign mdio_oe  = active && (is_wr || (bitidx < IDX_W'(TA_POS)));
  assign rdata    = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      bitidx <= '0;
      sh     <= '0;
    end else if (start) begin
      active <= 1'b1;
      is_wr  <= wr;
      bitidx <= '0;
      sh     <= build_frame(wr, phy, regn, wdata);
    end else if (active && fall_evt) begin
      if (last_bit) begin
        active <= 1'b0;
        sh     <= '0;
      end else begin
        bitidx <= bitidx + 1'b1;
        sh     <= {sh[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsh <= '0;
    else if (capture) rsh <= {rsh[DATA_W-2:0], mdio_i};
  end

  // R9: MDIO output moves only with an MDC fall or a frame start
  a_r9_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !start) |=> $stable(mdio_o));
  // R8: read data is only sampled while the pad is released
  a_r8_sample_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [31:0] addr_rd,
  output logic [15:0] data_rd,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              busy;
  logic              wr_f;
  logic [3:0]        cr_f;
  logic [ADDR_W-1:0] reg_f;
  logic [ADDR_W-1:0] phy_f;
  logic [DATA_W-1:0] data_q;

  logic              ctl_accept;
  logic              start;
  logic              seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic              rise_evt;
  logic              fall_evt;
  logic [DIV_W-1:0]  divisor;

  assign ctl_accept = reg_wr && !reg_sel && !busy;
  assign start      = ctl_accept && reg_wdata[0];
  assign divisor    = mdc_divisor(cr_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wr_f  <= 1'b0;
      cr_f  <= '0;
      reg_f <= '0;
      phy_f <= '0;
    end else if (ctl_accept) begin
      busy  <= reg_wdata[0];
      wr_f  <= reg_wdata[1];
      cr_f  <= reg_wdata[5:2];
      reg_f <= reg_wdata[10:6];
      phy_f <= reg_wdata[15:11];
    end else if (seq_done) begin
      busy  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  data_q <= '0;
    else if (seq_done && !wr_f)  data_q <= seq_rdata;
    else if (reg_wr && reg_sel)  data_q <= reg_wdata;
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .divisor  (divisor),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr       (reg_wdata[1]),
    .phy      (reg_wdata[15:11]),
    .regn     (reg_wdata[10:6]),
    .wdata    (data_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (seq_done),
    .rdata    (seq_rdata)
  );

  assign addr_rd = {16'h0000, phy_f, reg_f, cr_f, wr_f, busy};
  assign data_rd = data_q;

  // R6: MDC rests low whenever no frame is running
  a_r6_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R2: busy holds until the sequencer reports the end of the frame
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);
  // R3: control writes during a frame leave the fields untouched
  a_r3_ignore_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> $stable(addr_rd[15:1]));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel, mdio_i;
  logic [15:0] reg_wdata;
  logic [31:0] addr_rd;
  logic [15:0] data_rd;
  logic        mdc, mdio_o, mdio_oe;

  always #5 clk = ~clk;

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .addr_rd(addr_rd), .data_rd(data_rd),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_div(input logic [3:0] c);
    int slow [8] = '{42, 62, 16, 26, 102, 124, 124, 124};
    int fast [8] = '{4, 6, 8, 10, 12, 14, 4, 4};
    return c[3] ? fast[c[2:0]] : slow[c[2:0]];
  endfunction

  // behavioural reference model, updated on every rising edge
  bit          m_act, m_busy, m_wr;
  bit [3:0]    m_cr;
  bit [4:0]    m_phy, m_reg;
  bit [15:0]   m_data, phy_word;
  bit [63:0]   m_frame;
  int          m_n, m_div;

  always @(posedge clk) begin
    bit was_busy, rd_done;
    was_busy = m_busy;
    rd_done  = 1'b0;
    if (!rst_n) begin
      m_act = 0; m_busy = 0; m_wr = 0; m_cr = 0; m_phy = 0; m_reg = 0;
      m_data = 0; m_n = 0; m_div = 4; m_frame = 0;
    end else begin
      if (m_act) begin
        m_n++;
        if (m_n == 64 * m_div) begin
          m_act = 0; m_busy = 0;
          if (!m_wr) rd_done = 1;
        end
      end
      if (reg_wr && !reg_sel && !was_busy) begin
        m_wr = reg_wdata[1]; m_cr = reg_wdata[5:2];
        m_reg = reg_wdata[10:6]; m_phy = reg_wdata[15:11];
        if (reg_wdata[0]) begin
          m_busy = 1; m_act = 1; m_n = 0; m_div = ref_div(m_cr);
          m_frame[63:32] = 32'hFFFF_FFFF;
          m_frame[31:30] = 2'b01;
          m_frame[29:28] = m_wr ? 2'b01 : 2'b10;
          m_frame[27:23] = m_phy;
          m_frame[22:18] = m_reg;
          m_frame[17:16] = m_wr ? 2'b10 : 2'b00;
          m_frame[15:0]  = m_wr ? m_data : 16'h0;
        end
      end
      if (reg_wr && reg_sel) m_data = reg_wdata;
      if (rd_done) m_data = phy_word;
    end
  end

  // PHY model and per-clock comparison, away from the active edge
  bit [63:0] cap;
  int        capn;
  bit        last_mdc;

  always @(negedge clk) begin
    int k;
    bit e_mdc, e_oe;
    k = m_div > 0 ? m_n / m_div : 0;
    if (m_act && !m_wr && k >= 48) mdio_i = phy_word[15-(k-48)];
    else mdio_i = 1'b1;
    if (rst_n) begin
      e_mdc = m_act && ((m_n % m_div) >= (m_div / 2));
      e_oe  = m_act && (m_wr || k < 46);
      chk(mdc == e_mdc, "R6 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, "R8 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk(mdio_o == m_frame[63-k], "R7 mdio_o", 32'(mdio_o), 32'(m_frame[63-k]));
      chk(addr_rd == {16'h0, m_phy, m_reg, m_cr, m_wr, m_busy}, "R2 addr_rd", addr_rd,
          {16'h0, m_phy, m_reg, m_cr, m_wr, m_busy});
      chk(data_rd == m_data, "R11 data_rd", 32'(data_rd), 32'(m_data));
      if (mdc && !last_mdc && mdio_oe) begin
        cap = {cap[62:0], mdio_o};
        capn++;
      end
    end
    last_mdc = mdc;
  end

  task automatic reg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic xact(input bit wr, input logic [3:0] cr, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] rdw);
    int cyc;
    bit [63:0] exp_f;
    exp_f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, (wr ? 2'b10 : 2'b00),
             (wr ? wd : 16'h0)};
    if (wr) reg_write(1'b1, wd);
    phy_word = rdw;
    cap = 0; capn = 0;
    reg_write(1'b0, {phy, rg, cr, wr, 1'b1});
    chk(addr_rd[0] == 1'b1, "R2 busy set", 32'(addr_rd[0]), 32'd1);
    cyc = 0;
    while (addr_rd[0]) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 64 * ref_div(cr), cr[3] ? "R5 frame length" : "R4 frame length",
        32'(cyc), 32'(64 * ref_div(cr)));
    if (wr) begin
      chk(capn == 64 && cap == exp_f, "R7 write frame bits", cap[31:0], exp_f[31:0]);
    end else begin
      chk(capn == 46 && cap[45:0] == exp_f[63:18], "R7 read header bits", 32'(capn), 32'd46);
      chk(data_rd == rdw, "R8 read result", 32'(data_rd), 32'(rdw));
    end
    chk(addr_rd[31:16] == 16'h0, "R2 upper zero", addr_rd, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; phy_word = '0;
    repeat (3) @(negedge clk);
    chk(addr_rd == 0 && data_rd == 0, "R1 regs after reset", addr_rd, 32'h0);
    chk(!mdc && !mdio_oe, "R1 pins after reset", {30'h0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    xact(1'b1, 4'd0, 5'h11, 5'h0A, 16'hA5C3, 16'h0);
    xact(1'b0, 4'd1, 5'h1F, 5'h01, 16'h0,    16'h6B9E);
    for (int c = 2; c < 16; c++)
      xact(c[0], 4'(c), 5'(c * 3), 5'(31 - c), 16'(16'h1234 * c), 16'(16'hF00D ^ (c * 77)));

    // R10: a control write with bit 0 clear starts nothing
    cap = 0; capn = 0;
    reg_write(1'b0, {5'h07, 5'h1C, 4'd10, 1'b1, 1'b0});
    repeat (60) @(negedge clk);
    chk(addr_rd == {16'h0, 5'h07, 5'h1C, 4'd10, 1'b1, 1'b0}, "R10 fields stored",
        addr_rd, {16'h0, 5'h07, 5'h1C, 4'd10, 1'b1, 1'b0});
    chk(capn == 0 && !mdc && !mdio_oe, "R10 no frame", 32'(capn), 32'h0);

    // R11: data register load while idle
    reg_write(1'b1, 16'hBEEF);
    chk(data_rd == 16'hBEEF, "R11 data write", 32'(data_rd), 32'hBEEF);

    // R3: a control write during a read frame is ignored
    phy_word = 16'h5A0F;
    reg_write(1'b0, {5'h03, 5'h04, 4'd3, 1'b0, 1'b1});
    repeat (100) @(negedge clk);
    reg_write(1'b0, {5'h1E, 5'h1D, 4'd8, 1'b1, 1'b1});
    chk(addr_rd == {16'h0, 5'h03, 5'h04, 4'd3, 1'b0, 1'b1}, "R3 fields unchanged",
        addr_rd, {16'h0, 5'h03, 5'h04, 4'd3, 1'b0, 1'b1});
    while (addr_rd[0]) @(negedge clk);
    chk(data_rd == 16'h5A0F, "R3 frame completed", 32'(data_rd), 32'h5A0F);
    repeat (20) @(negedge clk);
    chk(!mdc && addr_rd[0] == 1'b0, "R3 no second frame", {31'h0, mdc}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd190000, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule